// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the event sequencer of an on-chip debug unit. On every rising clock edge it samples a set of trigger sources: a coprocessor breakpoint request, a software trigger, an external tag and four comparator match lines. When several of them fire in the same cycle, a fixed priority chain picks one winner and the rest are suppressed. The winner then moves a small state machine. The machine runs from a disarmed idle state, through three sequence states, toward a final state that marks the trace trigger point.

Software arms and disarms the sequencer with a write strobe. A 4-bit field for each sequence state says which match lines are taken there and where they lead. The trace-alignment mode decides two things: what the software trigger does, and when the forced breakpoint request is raised. The trace buffer and the comparators are outside the block. The block only reports the trigger point, the breakpoint request and an order to abort tracing.

Top module: `dbg_seq_top`

## Requirements
- R1: A synchronous active-high reset puts the block in state 0 (idle, disarmed), with `armed_o`, `bkpt_req_o`, `trig_pulse_o` and `trace_kill_o` all low. States are encoded as 0 = idle, 1 to 3 = sequence states, 4 = final.
- R2: An arm write with `arm_val`=1 in state 0 moves the block to state 1 on the next cycle. An arm write with `arm_val`=0 returns the block from any state to state 0 with no pulse output, and all triggers are ignored in that cycle. An arm write with `arm_val`=1 while the block is already armed has no effect.
- R3: Triggers act only in states 1 to 3. In state 0 and in the final state they are ignored.
- R4: When triggers coincide, exactly one acts, chosen in this order: coprocessor breakpoint, software trigger, external tag, then the matches. A coprocessor breakpoint raises `bkpt_req_o` and `trace_kill_o` for one cycle, whatever `bkpt_en` is, and returns the block to state 0.
- R5: `align_mode` encodes 0 = none, 1 = begin, 2 = mid, 3 = end. Under begin or mid, the software trigger enters the final state. Under end or none, it returns the block to state 0 and raises `bkpt_req_o` when `bkpt_en`=1. In both cases `trig_pulse_o` pulses for one cycle.
- R6: An external tag returns the block to state 0 with no breakpoint and no trigger pulse.
- R7: In sequence state s, the field is `seq_cfg[4(s-1)+3 : 4(s-1)]`. If bit 2 is set, the lowest-numbered active match k (other than the final-mapped match) moves the block to state ((s+k) mod 3)+1. If bit 2 is clear, such matches are ignored.
- R8: If bit 3 of the field is set and match[bits 1:0] is active, the block enters the final state, ahead of any lower-numbered match.
- R9: When `range_mode`=1 and match0 is active, match2 is dropped before any decision is made.
- R10: Under begin or mid alignment, the final state holds until `trace_done` is sampled high. The block then returns to state 0 and raises `bkpt_req_o` when `bkpt_en`=1.
- R11: Under end or none alignment, the final state lasts one cycle. `bkpt_req_o` is raised on entry when `bkpt_en`=1.
- R12: An arm write with `arm_val`=1 in the same cycle as a hardware disarm (coprocessor breakpoint, external tag, or software trigger under end or none) leaves the block in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_wr | input | 1 | Arm control write strobe |
| arm_val | input | 1 | Arm value written |
| sw_trig | input | 1 | Software trigger |
| ext_tag | input | 1 | External tag trigger |
| cop_bkpt | input | 1 | Coprocessor breakpoint request |
| match_in | input | 4 | Comparator match lines 0..3 |
| range_mode | input | 1 | Range mode: match0 suppresses match2 |
| seq_cfg | input | 12 | Next-state fields for states 1..3 |
| align_mode | input | 2 | Trace alignment |
| bkpt_en | input | 1 | Breakpoint enable |
| trace_done | input | 1 | Trace buffer has completed |
| state_o | output | 3 | Current state |
| armed_o | output | 1 | Sequencer armed |
| bkpt_req_o | output | 1 | Forced breakpoint request pulse |
| trig_pulse_o | output | 1 | Final-state entry (trace trigger point) |
| trace_kill_o | output | 1 | Immediate trace abort pulse |

## Verification
The bench drives triggers that coincide in pairs and in full bursts. Each pair is chosen so that the higher and the lower source lead to different states or pulses, which shows which one won. Match pairs are applied under advance-only fields and under final-mapped fields, with and without range mode. These patterns separate the lowest-index rule, the rule that the final-mapped match wins, and the dropping of match2. The software trigger is applied under each alignment family, so the final-state route and the disarm route can each be confirmed. Arm writes are applied alone, while the block is already armed, together with hardware disarms, and as clears, to check the arm-control cases.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
    localparam int SEQ_N   = 3;
    localparam int MATCH_N = 4;
    localparam int CFG_W   = 4;
    localparam int STW     = $clog2(SEQ_N + 2);

    typedef logic [STW-1:0] st_t;
    localparam st_t ST_IDLE  = st_t'(0);
    localparam st_t ST_FINAL = st_t'(SEQ_N + 1);

    typedef enum logic [1:0] {AL_NONE, AL_BEGIN, AL_MID, AL_END} align_e;
    typedef enum logic [2:0] {WIN_NONE, WIN_COP, WIN_SW, WIN_TAG, WIN_MATCH} win_e;

    typedef struct packed {
        win_e               kind;
        logic [MATCH_N-1:0] mvec;
    } win_t;

    typedef struct packed {
        logic hit;
        st_t  dest;
    } route_t;

    function automatic logic traces_first(align_e a);
        return (a == AL_BEGIN) || (a == AL_MID);
    endfunction

    function automatic st_t adv_dest(st_t s, int k);
        return st_t'(((int'(s) + k) % SEQ_N) + 1);
    endfunction
endpackage

// File: rtl/dbg_trig_prio.sv
module dbg_trig_prio
    import dbg_seq_pkg::*;
(
    input  logic               active,
    input  logic               cop,
    input  logic               sw,
    input  logic               tag,
    input  logic               range_mode,
    input  logic [MATCH_N-1:0] match,
    output win_t               win
);
    logic [MATCH_N-1:0] mv;

    always_comb begin
        mv = match;
        if (range_mode && match[0]) mv[2] = 1'b0;
        win.mvec = mv;
        if (!active)     win.kind = WIN_NONE;
        else if (cop)    win.kind = WIN_COP;
        else if (sw)     win.kind = WIN_SW;
        else if (tag)    win.kind = WIN_TAG;
        else if (|mv)    win.kind = WIN_MATCH;
        else             win.kind = WIN_NONE;
    end
endmodule

// File: rtl/dbg_match_route.sv
module dbg_match_route
    import dbg_seq_pkg::*;
(
    input  st_t                      state,
    input  logic [CFG_W*SEQ_N-1:0]   cfg,
    input  logic [MATCH_N-1:0]       mvec,
    output route_t                   rt
);
    logic [CFG_W-1:0] fld [SEQ_N];
    logic [CFG_W-1:0] cur;
    logic [1:0]       fin_idx;

    for (genvar g = 0; g < SEQ_N; g++) begin : g_fld
        assign fld[g] = cfg[g*CFG_W +: CFG_W];
    end

    always_comb begin
        cur = '0;
        for (int s = 0; s < SEQ_N; s++) begin
            if (state == st_t'(s + 1)) cur = fld[s];
        end
        fin_idx = cur[1:0];
        rt = '0;
        if (cur[3] && mvec[fin_idx]) begin
            rt.hit  = 1'b1;
            rt.dest = ST_FINAL;
        end else if (cur[2]) begin
            for (int k = MATCH_N - 1; k >= 0; k--) begin
                if (mvec[k] && !(cur[3] && int'(fin_idx) == k)) begin
                    rt.hit  = 1'b1;
                    rt.dest = adv_dest(state, k);
                end
            end
        end
    end
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
    import dbg_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   arm_wr,
    input  logic   arm_val,
    input  win_t   win,
    input  route_t rt,
    input  align_e align,
    input  logic   bkpt_en,
    input  logic   trace_done,
    output st_t    state,
    output logic   bkpt_q,
    output logic   trig_q,
    output logic   kill_q
);
    st_t  nxt;
    logic bk, tg, kl, tf, clr_wr, active;

    assign tf     = traces_first(align);
    assign clr_wr = arm_wr && !arm_val;
    assign active = (state != ST_IDLE) && (state != ST_FINAL);

    always_comb begin
        nxt = state;
        bk  = 1'b0;
        tg  = 1'b0;
        kl  = 1'b0;
        if (clr_wr) begin
            nxt = ST_IDLE;
        end else if (state == ST_IDLE) begin
            if (arm_wr && arm_val) nxt = st_t'(1);
        end else if (state == ST_FINAL) begin
            if (!tf) begin
                nxt = ST_IDLE;
            end else if (trace_done) begin
                nxt = ST_IDLE;
                bk  = bkpt_en;
            end
        end else begin
            case (win.kind)
                WIN_COP: begin
                    nxt = ST_IDLE;
                    bk  = 1'b1;
                    kl  = 1'b1;
                end
                WIN_SW: begin
                    tg = 1'b1;
                    if (tf) nxt = ST_FINAL;
                    else begin
                        nxt = ST_IDLE;
                        bk  = bkpt_en;
                    end
                end
                WIN_TAG: nxt = ST_IDLE;
                WIN_MATCH: begin
                    if (rt.hit) begin
                        nxt = rt.dest;
                        if (rt.dest == ST_FINAL) begin
                            tg = 1'b1;
                            bk = bkpt_en && !tf;
                        end
                    end
                end
                default: nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            bkpt_q <= 1'b0;
            trig_q <= 1'b0;
            kill_q <= 1'b0;
        end else begin
            state  <= nxt;
            bkpt_q <= bk;
            trig_q <= tg;
            kill_q <= kl;
        end
    end

    p_state_legal_r1: assert property (@(posedge clk) disable iff (rst)
        state <= ST_FINAL);
    p_clear_write_r2: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> (state == ST_IDLE) && !bkpt_q && !trig_q && !kill_q);
    p_arm_start_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) && arm_wr && arm_val |=> state == st_t'(1));
    p_cop_abort_r4: assert property (@(posedge clk) disable iff (rst)
        active && win.kind == WIN_COP && !clr_wr |=> bkpt_q && kill_q && state == ST_IDLE);
    p_final_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FINAL) && ($past(state) != ST_FINAL) |-> trig_q);
    p_tag_home_r6: assert property (@(posedge clk) disable iff (rst)
        active && win.kind == WIN_TAG && !clr_wr |=> state == ST_IDLE && !bkpt_q);
    p_final_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FINAL) && tf && !trace_done && !clr_wr |=> state == ST_FINAL);
    p_final_leave_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FINAL) && !tf |=> state == ST_IDLE);
    p_arm_race_r12: assert property (@(posedge clk) disable iff (rst)
        active && arm_wr && arm_val && (win.kind == WIN_COP || win.kind == WIN_TAG)
        |=> state == ST_IDLE);
endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
    import dbg_seq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     arm_wr,
    input  logic                     arm_val,
    input  logic                     sw_trig,
    input  logic                     ext_tag,
    input  logic                     cop_bkpt,
    input  logic [MATCH_N-1:0]       match_in,
    input  logic                     range_mode,
    input  logic [CFG_W*SEQ_N-1:0]   seq_cfg,
    input  logic [1:0]               align_mode,
    input  logic                     bkpt_en,
    input  logic                     trace_done,
    output logic [STW-1:0]           state_o,
    output logic                     armed_o,
    output logic                     bkpt_req_o,
    output logic                     trig_pulse_o,
    output logic                     trace_kill_o
);
    st_t    state;
    win_t   win;
    route_t rt;
    logic   in_seq;

    assign in_seq = (state != ST_IDLE) && (state != ST_FINAL);

    dbg_trig_prio u_prio (
        .active     (in_seq),
        .cop        (cop_bkpt),
        .sw         (sw_trig),
        .tag        (ext_tag),
        .range_mode (range_mode),
        .match      (match_in),
        .win        (win)
    );

    dbg_match_route u_route (
        .state (state),
        .cfg   (seq_cfg),
        .mvec  (win.mvec),
        .rt    (rt)
    );

    dbg_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .arm_wr     (arm_wr),
        .arm_val    (arm_val),
        .win        (win),
        .rt         (rt),
        .align      (align_e'(align_mode)),
        .bkpt_en    (bkpt_en),
        .trace_done (trace_done),
        .state      (state),
        .bkpt_q     (bkpt_req_o),
        .trig_q     (trig_pulse_o),
        .kill_q     (trace_kill_o)
    );

    assign state_o = state;
    assign armed_o = (state != ST_IDLE);
endmodule

// File: tb/dbg_seq_top_test.sv
module dbg_seq_top_test;
    logic clk = 1'b0;
    logic rst, arm_wr, arm_val, sw_trig, ext_tag, cop_bkpt, range_mode, bkpt_en, trace_done;
    logic [3:0]  match_in;
    logic [11:0] seq_cfg;
    logic [1:0]  align_mode;
    logic [2:0]  state_o;
    logic armed_o, bkpt_req_o, trig_pulse_o, trace_kill_o;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dbg_seq_top uut (
        .clk(clk), .rst(rst), .arm_wr(arm_wr), .arm_val(arm_val),
        .sw_trig(sw_trig), .ext_tag(ext_tag), .cop_bkpt(cop_bkpt),
        .match_in(match_in), .range_mode(range_mode), .seq_cfg(seq_cfg),
        .align_mode(align_mode), .bkpt_en(bkpt_en), .trace_done(trace_done),
        .state_o(state_o), .armed_o(armed_o), .bkpt_req_o(bkpt_req_o),
        .trig_pulse_o(trig_pulse_o), .trace_kill_o(trace_kill_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        arm_wr = 0; arm_val = 0; sw_trig = 0; ext_tag = 0; cop_bkpt = 0;
        match_in = 0; trace_done = 0;
    endtask

    task automatic arm_now();
        quiet(); arm_wr = 1; arm_val = 1; tick(); quiet();
    endtask

    task automatic disarm_now();
        quiet(); arm_wr = 1; arm_val = 0; tick(); quiet();
    endtask

    task automatic t_reset();
        quiet(); range_mode = 0; seq_cfg = 0; align_mode = 0; bkpt_en = 0;
        rst = 1; tick(); tick(); rst = 0;
        chk("R1 state", state_o, 0);
        chk("R1 armed", armed_o, 0);
        chk("R1 bkpt", bkpt_req_o, 0);
        chk("R1 trig", trig_pulse_o, 0);
        chk("R1 kill", trace_kill_o, 0);
    endtask

    task automatic t_idle_arm();
        seq_cfg = 12'h444; align_mode = 2'd1; bkpt_en = 1;
        cop_bkpt = 1; sw_trig = 1; ext_tag = 1; match_in = 4'hF; tick(); quiet();
        chk("R3 idle state", state_o, 0);
        chk("R3 idle bkpt", bkpt_req_o, 0);
        arm_now();
        chk("R2 arm", state_o, 1);
        chk("R2 armed flag", armed_o, 1);
        arm_now();
        chk("R2 rearm no effect", state_o, 1);
    endtask

    task automatic t_cop_prio();
        align_mode = 2'd1; bkpt_en = 0;
        cop_bkpt = 1; sw_trig = 1; ext_tag = 1; match_in = 4'hF; tick(); quiet();
        chk("R4 cop bkpt", bkpt_req_o, 1);
        chk("R4 cop kill", trace_kill_o, 1);
        chk("R4 cop state", state_o, 0);
        chk("R4 cop no trig", trig_pulse_o, 0);
    endtask

    task automatic t_sw_begin();
        arm_now(); align_mode = 2'd1; bkpt_en = 1;
        sw_trig = 1; ext_tag = 1; match_in = 4'h1; tick(); quiet();
        chk("R5 begin final", state_o, 4);
        chk("R5 trig", trig_pulse_o, 1);
        chk("R5 no bkpt", bkpt_req_o, 0);
        tick();
        chk("R10 hold", state_o, 4);
        chk("R3 final ignores", armed_o, 1);
        ext_tag = 1; tick(); quiet();
        chk("R3 tag in final", state_o, 4);
        trace_done = 1; tick(); quiet();
        chk("R10 exit", state_o, 0);
        chk("R10 bkpt", bkpt_req_o, 1);
    endtask

    task automatic t_sw_end();
        arm_now(); align_mode = 2'd3; bkpt_en = 1;
        sw_trig = 1; ext_tag = 1; tick(); quiet();
        chk("R5 end state", state_o, 0);
        chk("R5 end bkpt", bkpt_req_o, 1);
        chk("R5 end trig", trig_pulse_o, 1);
        arm_now(); align_mode = 2'd0; bkpt_en = 0;
        sw_trig = 1; tick(); quiet();
        chk("R5 none state", state_o, 0);
        chk("R5 none bkpt", bkpt_req_o, 0);
    endtask

    task automatic t_tag();
        seq_cfg = 12'h444; arm_now(); align_mode = 2'd3; bkpt_en = 1;
        ext_tag = 1; match_in = 4'h1; tick(); quiet();
        chk("R6 state", state_o, 0);
        chk("R6 bkpt", bkpt_req_o, 0);
        chk("R6 trig", trig_pulse_o, 0);
    endtask

    task automatic t_match_prio();
        seq_cfg = 12'h444; arm_now();
        match_in = 4'b0011; tick(); quiet();
        chk("R7 m0 over m1", state_o, 2);
        match_in = 4'b1010; tick(); quiet();
        chk("R7 m1 from s2", state_o, 1);
        match_in = 4'b0010; tick(); quiet();
        chk("R7 m1 from s1", state_o, 3);
        disarm_now();
        seq_cfg = 12'h000; arm_now();
        match_in = 4'hF; tick(); quiet();
        chk("R7 unmapped", state_o, 1);
        seq_cfg = 12'h00B;
        match_in = 4'b0001; tick(); quiet();
        chk("R7 no advance", state_o, 1);
        disarm_now();
    endtask

    task automatic t_final_wins();
        seq_cfg = 12'h00F; align_mode = 2'd3; bkpt_en = 1; arm_now();
        match_in = 4'b1001; tick(); quiet();
        chk("R8 final wins", state_o, 4);
        chk("R11 entry bkpt", bkpt_req_o, 1);
        chk("R8 trig", trig_pulse_o, 1);
        tick();
        chk("R11 leave", state_o, 0);
        chk("R11 single bkpt", bkpt_req_o, 0);
    endtask

    task automatic t_range();
        seq_cfg = 12'h00E; align_mode = 2'd1; range_mode = 1; arm_now();
        match_in = 4'b0101; tick(); quiet();
        chk("R9 m2 dropped", state_o, 2);
        disarm_now(); range_mode = 0; arm_now();
        match_in = 4'b0101; tick(); quiet();
        chk("R9 m2 kept", state_o, 4);
        arm_wr = 1; arm_val = 0; trace_done = 1; bkpt_en = 1; tick(); quiet();
        chk("R2 clear from final", state_o, 0);
        chk("R2 clear no bkpt", bkpt_req_o, 0);
    endtask

    task automatic t_race();
        arm_now(); arm_wr = 1; arm_val = 1; ext_tag = 1; tick(); quiet();
        chk("R12 tag race", state_o, 0);
        arm_now(); align_mode = 2'd3;
        arm_wr = 1; arm_val = 1; sw_trig = 1; tick(); quiet();
        chk("R12 sw race", state_o, 0);
        seq_cfg = 12'h444; arm_now(); match_in = 4'b0001; tick(); quiet();
        arm_wr = 1; arm_val = 0; cop_bkpt = 1; tick(); quiet();
        chk("R2 clear over cop", state_o, 0);
        chk("R2 clear no kill", trace_kill_o, 0);
    endtask

    initial begin
        rst = 1;
        t_reset();
        t_idle_arm();
        t_cop_prio();
        t_sw_begin();
        t_sw_end();
        t_tag();
        t_match_prio();
        t_final_wins();
        t_range();
        t_race();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule